// File: doc/BRIEF.md
# Position Scan Controller

This block runs one position search at a time over an array of sense points. A receiver raises its ready line to ask for a measurement. The controller clears an internal scan counter and steps it by one every clock. When the synchronous detection input arrives, the current count is the position. That value is copied into an output register through an active-low load strobe, and data-valid is raised. Data-valid holds until the receiver drops ready. The controller then clears itself and waits for the next request.

If the counter runs past its largest value with no detection, the sensor was not found. In that case the error output is raised instead of data-valid, and it also holds until ready is released. The ready input comes from another timing domain and passes through one flip-flop before the state machine sees it. The detection input is taken as already synchronous.

Top module: `scan_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, `dav` and `err` are 0 and `pos` is all zeros.
- R2: `rdy_raw` passes through one rising-edge flip-flop before the state machine acts on it, so each ready change takes effect one clock later than it would if sampled directly.
- R3: Each new scan starts at count 0, and the count rises by one on every clock the machine spends scanning.
- R4: If `hit` is 1 on a scanning clock, the count held at that clock is stored in `pos`, and `dav` goes to 1 two clocks later.
- R5: `dav` stays at 1, and `pos` stays unchanged, until the synchronized ready has been seen low. `dav` then falls, and the machine clears the counter and waits for ready again.
- R6: If the count is at its maximum value (all ones, 2^W−1) on a scanning clock and `hit` is 0, the scan stops. `err` goes to 1 and `pos` keeps its previous value.
- R7: A hit on the clock where the count is at its maximum value takes priority over overflow, so `pos` becomes 2^W−1 and `err` stays 0.
- R8: `err` stays at 1 until the synchronized ready is low, then falls, and a new scan can be started. `dav` and `err` are never both 1.
- R9: `hit` has no effect outside scanning. While the machine is waiting, loading or in error, `pos` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy_raw | input | 1 | Receiver ready, not yet synchronized |
| hit | input | 1 | Synchronous detection pulse from the sense array |
| dav | output | 1 | Captured position is valid |
| err | output | 1 | Scan overflowed and the sensor was not found |
| pos | output | W | Captured position |

## Verification
The bench builds the block with the default width of 4 bits. With that width, a full sweep that ends in overflow takes only 16 scanning clocks, so the error path, the hit on the last count and the hit on the first count can all be reached in short runs. A behavioural model of the sequence is compared with `dav`, `err` and `pos` on every clock. Hits are timed from the model's own count, so positions 0, mid-range and 15 can each be placed exactly.

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rdy_raw,
  input  logic         hit,
  output logic         dav,
  output logic         err,
  output logic [W-1:0] pos
);
  localparam logic [W-1:0] CMAX = '1;

  typedef enum logic [2:0] {S_CLR, S_IDLE, S_SCAN, S_LOAD, S_FAIL} st_t;

  st_t          st, nx;
  logic         srdy, ld_seen;
  logic [W-1:0] cnt;

  wire ovf  = (cnt == CMAX);
  wire ld_n = (st != S_LOAD);

  always_comb begin
    nx = st;
    case (st)
      S_CLR:  nx = S_IDLE;
      S_IDLE: if (srdy) nx = S_SCAN;
      S_SCAN: if (hit) nx = S_LOAD; else if (ovf) nx = S_FAIL;
      S_LOAD: if (ld_seen && !srdy) nx = S_CLR;
      S_FAIL: if (!srdy) nx = S_CLR;
      default: nx = S_CLR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_CLR;
      srdy    <= 1'b0;
      ld_seen <= 1'b0;
      cnt     <= '0;
      pos     <= '0;
    end else begin
      st      <= nx;
      srdy    <= rdy_raw;
      ld_seen <= (st == S_LOAD);
      if (st == S_CLR) cnt <= '0;
      else if (st == S_SCAN && !hit && !ovf) cnt <= cnt + 1'b1;
      if (!ld_n) pos <= cnt;
    end
  end

  assign dav = (st == S_LOAD) && ld_seen;
  assign err = (st == S_FAIL);

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_CLR) |-> cnt == '0);
  assert_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN && $past(st) == S_IDLE) |-> $past(srdy));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dav && $past(dav)) |-> $stable(pos));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav) |-> !$past(srdy));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (cnt == CMAX && !$past(hit)));
  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dav && err));
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_IDLE || $past(st) == S_FAIL) |-> $stable(pos));
endmodule

// File: tb/tb_scan_ctrl.sv
module tb_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 0, rst_n = 0, rdy_raw = 0, hit = 0;
  logic dav, err;
  logic [W-1:0] pos;

  scan_ctrl #(.W(W)) dut (.clk(clk), .rst_n(rst_n), .rdy_raw(rdy_raw), .hit(hit),
                          .dav(dav), .err(err), .pos(pos));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // model: 0 clear, 1 wait, 2 scan, 3 load, 4 error
  int ms = 0, mc = 0, mp = 0;
  bit msr = 0, mld = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mc = 0; mp = 0; msr = 0; mld = 0;
    end else begin
      int ns;
      ns = ms;
      case (ms)
        0: begin ns = 1; mc = 0; end
        1: if (msr) ns = 2;
        2: if (hit) ns = 3; else if (mc == MAXC) ns = 4; else mc = mc + 1;
        3: begin mp = mc; if (mld && !msr) ns = 0; end
        4: if (!msr) ns = 0;
        default: ns = 0;
      endcase
      mld = (ms == 3);
      msr = rdy_raw;
      ms = ns;
    end
  end

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check({tag, " dav"}, dav, (ms == 3 && mld) ? 1 : 0);
    check({tag, " err"}, err, (ms == 4) ? 1 : 0);
    check({tag, " pos"}, pos, mp);
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hit_at(int k);
    do @(negedge clk); while (!(ms == 2 && mc == k));
    hit = 1;
    @(negedge clk);
    hit = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    wait_cyc(3);
    tag = "R1";
    check("R1 reset dav", dav, 0);
    check("R1 reset pos", pos, 0);
    rst_n = 1;
    wait_cyc(3);
    check("R1 idle err", err, 0);

    tag = "R2 R3 R4";
    rdy_raw = 1;
    hit_at(5);
    wait_cyc(1);
    check("R4 dav after two clocks", dav, 1);
    check("R3 position", pos, 5);

    tag = "R9";
    hit = 1; wait_cyc(2); hit = 0;
    check("R9 pos during load", pos, 5);

    tag = "R5";
    wait_cyc(4);
    check("R5 dav held", dav, 1);
    rdy_raw = 0;
    wait_cyc(1);
    check("R5 dav still high (sync delay)", dav, 1);
    wait_cyc(1);
    check("R5 dav released", dav, 0);

    tag = "R9";
    hit = 1; wait_cyc(4); hit = 0;
    check("R9 pos while waiting", pos, 5);

    tag = "R3";
    rdy_raw = 1;
    hit_at(0);
    wait_cyc(2);
    check("R3 first count position", pos, 0);
    rdy_raw = 0; wait_cyc(4);

    tag = "R7";
    rdy_raw = 1;
    hit_at(MAXC);
    wait_cyc(2);
    check("R7 max hit pos", pos, MAXC);
    check("R7 no err", err, 0);
    rdy_raw = 0; wait_cyc(4);

    tag = "R6 R8";
    rdy_raw = 1;
    wait_cyc(25);
    check("R6 err raised", err, 1);
    check("R6 pos kept", pos, MAXC);
    tag = "R9";
    hit = 1; wait_cyc(2); hit = 0;
    check("R9 pos in error", pos, MAXC);
    tag = "R8";
    rdy_raw = 0;
    wait_cyc(3);
    check("R8 err cleared", err, 0);
    rdy_raw = 1;
    hit_at(9);
    wait_cyc(2);
    check("R8 rescan position", pos, 9);
    rdy_raw = 0;
    wait_cyc(5);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end
endmodule